// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block keeps the two error counters of a CAN node, one for transmit and one for receive, and derives the node's fault-confinement state from them. A protocol engine sends it single-cycle event strobes. These report an error seen while sending, an error seen while receiving (an ordinary one or a severe one), a frame sent or received without error, and each detection of a run of 11 recessive bits. The block returns both counter values, warning and passive flags for each counter, the node state, and whether the next error flag must be sent as recessive bits rather than dominant bits.

The node is error active while both counters stay below 128. It is error passive when either counter is at 128 or more. It is bus off once the transmit counter reaches 256. While the node is bus off, the counters are frozen. The node comes back only after 128 detections of 11 recessive bits: both counters then clear and the node is error active again. Error detection and frame handling stay in the protocol engine.

Top module: `can_fault_conf`

## Requirements
- R1: A synchronous active-low reset clears both counters, all flags and the recovery progress; `err_state` reads 0 (error active).
- R2: A `tx_err` strobe adds 8 to the transmit counter. A `tx_ok` strobe subtracts 1, and a counter already at 0 stays at 0. When both strobes arrive in the same cycle, `tx_err` wins.
- R3: A `rx_err` strobe adds 1 to the receive counter and a `rx_err_hi` strobe adds 8. The counter saturates at 255. When both strobes arrive together, `rx_err_hi` wins.
- R4: A `rx_ok` strobe sets a receive count above 127 to 127, lowers a count of 1 to 127 by 1, and leaves 0 at 0. Either receive error strobe takes precedence over `rx_ok`.
- R5: `tx_warn` is 1 exactly when the transmit counter is 96 or more, and `rx_warn` is 1 exactly when the receive counter is 96 or more.
- R6: `tx_passive` is 1 when the transmit counter is 128 or more, and `rx_passive` is 1 when the receive counter is 128 or more. `err_state` reads 1 (error passive) when either counter is 128 or more and the node is not bus off. `flag_recessive` is 1 exactly when `err_state` is 1 (6 recessive bits), and 0 otherwise (6 dominant bits).
- R7: `bus_off` is 1 and `err_state` reads 2 exactly when the transmit counter is 256 or more. While the node is bus off, every error and success strobe leaves both counters unchanged.
- R8: While the node is bus off, the 128th `idle11` strobe clears both counters at that clock edge, so `bus_off` drops and `err_state` returns to 0. `idle11` strobes received while the node is not bus off have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_err | input | 1 | Error detected while transmitting |
| rx_err | input | 1 | Error detected while receiving, ordinary weight |
| rx_err_hi | input | 1 | Error detected while receiving, severe weight |
| tx_ok | input | 1 | Frame transmitted without error |
| rx_ok | input | 1 | Frame received without error |
| idle11 | input | 1 | 11 consecutive recessive bits detected |
| tec | output | 9 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| tx_warn | output | 1 | Transmit counter at 96 or more |
| rx_warn | output | 1 | Receive counter at 96 or more |
| tx_passive | output | 1 | Transmit counter at 128 or more |
| rx_passive | output | 1 | Receive counter at 128 or more |
| bus_off | output | 1 | Node is bus off |
| err_state | output | 2 | 0 error active, 1 error passive, 2 bus off |
| flag_recessive | output | 1 | Error flag is to be sent as recessive bits |

## Verification
Every flag is decoded directly from the counters, so a wrong count shows on `tec` or `rec` on the first clock edge after the strobe that caused it. Once the count crosses 96, 128 or 256, the same error also shows on a flag. A recovery counter that runs fast or slow is visible only when bus off is left one detection early or late. For that reason the bench counts exactly 128 detections across several bus-off episodes, with `idle11` strobes placed outside bus off between them. A bad clipping or saturation rule shows when the receive counter sits above 127 or near 255, so the bench drives it into those regions before checking successes.

// File: rtl/fc_pkg.sv
// Shared types for the fault confinement counters.
// Assumes: the state encoding below is what the node state port carries.
package fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;
endpackage

// File: rtl/fc_tx_cnt.sv
// Transmit error counter: adds STEP on an error and subtracts 1 on a success,
// with a floor at zero. Holds while frozen; a clear overrides everything.
// Assumes: W is wide enough to hold the bus-off limit plus one STEP.
module fc_tx_cnt #(
    parameter int W    = 9,
    parameter int STEP = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         freeze,
    input  logic         err,
    input  logic         ok,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    // Update the count from the strobes; the error strobe outranks success.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)       cnt <= '0;
        else if (freeze)         cnt <= cnt;
        else if (err)            cnt <= cnt + STEP_V;
        else if (ok && cnt != 0) cnt <= cnt - 1'b1;
    end

    a_r2_tx_add: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !freeze && !clr) |=> (cnt == $past(cnt) + STEP_V));
    a_r2_tx_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && !err && !freeze && !clr && cnt == 0) |=> (cnt == 0));
endmodule

// File: rtl/fc_rx_cnt.sv
// Receive error counter: adds 1 or STEP_HI on an error, saturating at the top
// of its range. On a success, a count above CLIP is set to CLIP and a nonzero
// count at or below CLIP is lowered by 1. Holds while frozen; a clear overrides.
// Assumes: CLIP is below 2**W - 1.
module fc_rx_cnt #(
    parameter int W       = 8,
    parameter int STEP_HI = 8,
    parameter int CLIP    = 127
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         freeze,
    input  logic         err,
    input  logic         err_hi,
    input  logic         ok,
    output logic [W-1:0] cnt
);
    localparam int       MAXV = (1 << W) - 1;
    localparam logic [W-1:0] CLIP_V = W'(CLIP);

    logic [W:0] sum;

    // Add the error weight one bit wider so saturation can be detected.
    always_comb begin
        sum = {1'b0, cnt} + (err_hi ? (W+1)'(STEP_HI) : (W+1)'(1));
    end

    // Update the count from the strobes; the severe error outranks the others.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)             cnt <= '0;
        else if (freeze)               cnt <= cnt;
        else if (err || err_hi)        cnt <= (sum > (W+1)'(MAXV)) ? W'(MAXV) : sum[W-1:0];
        else if (ok && cnt > CLIP_V)   cnt <= CLIP_V;
        else if (ok && cnt != 0)       cnt <= cnt - 1'b1;
    end

    a_r4_rx_clip: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && !err && !err_hi && !freeze && !clr && cnt > CLIP_V) |=> (cnt == CLIP_V));
    a_r3_rx_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((err || err_hi) && !freeze && !clr) |=> (cnt >= $past(cnt)));
endmodule

// File: rtl/fc_recover.sv
// Bus-off recovery counter: while the node is bus off, counts the detections
// of 11 recessive bits and pulses done on the N-th. It is held at zero at all
// other times.
// Assumes: N >= 1.
module fc_recover #(
    parameter int N = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busoff,
    input  logic idle11,
    output logic done
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] seen;

    // Pulse done on the detection that completes the required count.
    always_comb done = busoff && idle11 && (seen == LAST);

    // Count detections only while bus off; restart after done or outside bus off.
    always_ff @(posedge clk) begin
        if (!rst_n || !busoff || done) seen <= '0;
        else if (idle11)               seen <= seen + 1'b1;
    end

    a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        seen <= LAST);
    a_r8_idle_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !busoff |=> (seen == 0));
endmodule

// File: rtl/can_fault_conf.sv
// CAN fault confinement: the transmit and receive error counters and the node
// state derived from them (error active, error passive, bus off), with bus-off
// recovery after a fixed number of 11-recessive-bit detections.
// Assumes: each strobe lasts one clock cycle per event.
module can_fault_conf #(
    parameter int TX_W       = 9,
    parameter int RX_W       = 8,
    parameter int ERR_STEP   = 8,
    parameter int WARN_LVL   = 96,
    parameter int PASS_LVL   = 128,
    parameter int BUSOFF_LVL = 256,
    parameter int RECOV_N    = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_err,
    input  logic            rx_err,
    input  logic            rx_err_hi,
    input  logic            tx_ok,
    input  logic            rx_ok,
    input  logic            idle11,
    output logic [TX_W-1:0] tec,
    output logic [RX_W-1:0] rec,
    output logic            tx_warn,
    output logic            rx_warn,
    output logic            tx_passive,
    output logic            rx_passive,
    output logic            bus_off,
    output logic [1:0]      err_state,
    output logic            flag_recessive
);
    import fc_pkg::*;

    localparam int CLIP = PASS_LVL - 1;

    logic      recovered;
    fc_state_e state;

    fc_tx_cnt #(.W(TX_W), .STEP(ERR_STEP)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(recovered), .freeze(bus_off),
        .err(tx_err), .ok(tx_ok), .cnt(tec));

    fc_rx_cnt #(.W(RX_W), .STEP_HI(ERR_STEP), .CLIP(CLIP)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(recovered), .freeze(bus_off),
        .err(rx_err), .err_hi(rx_err_hi), .ok(rx_ok), .cnt(rec));

    fc_recover #(.N(RECOV_N)) u_rcv (
        .clk(clk), .rst_n(rst_n), .busoff(bus_off), .idle11(idle11),
        .done(recovered));

    // Decode the flags and the node state from the two counters.
    always_comb begin
        tx_warn    = tec >= TX_W'(WARN_LVL);
        rx_warn    = rec >= RX_W'(WARN_LVL);
        tx_passive = tec >= TX_W'(PASS_LVL);
        rx_passive = rec >= RX_W'(PASS_LVL);
        bus_off    = tec >= TX_W'(BUSOFF_LVL);
        if (bus_off)                       state = FC_BUSOFF;
        else if (tx_passive || rx_passive) state = FC_PASSIVE;
        else                               state = FC_ACTIVE;
        err_state      = state;
        flag_recessive = (state == FC_PASSIVE);
    end

    a_r7_busoff_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && !idle11) |=> ($stable(tec) && $stable(rec)));
    a_r8_recover_clears: assert property (@(posedge clk) disable iff (!rst_n)
        recovered |=> (tec == 0 && rec == 0 && !bus_off));
    a_r6_flag_type: assert property (@(posedge clk) disable iff (!rst_n)
        flag_recessive |-> (!bus_off && (tec >= TX_W'(PASS_LVL) || rec >= RX_W'(PASS_LVL))));
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (tec == 0 && rec == 0));
endmodule

// File: tb/sim_can_fault_conf.sv
module sim_can_fault_conf;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_err = 0, rx_err = 0, rx_err_hi = 0, tx_ok = 0, rx_ok = 0, idle11 = 0;
    logic [8:0] tec;
    logic [7:0] rec;
    logic tx_warn, rx_warn, tx_passive, rx_passive, bus_off, flag_recessive;
    logic [1:0] err_state;

    int n_chk = 0, n_bad = 0;
    int mtec = 0, mrec = 0, mrc = 0;
    logic [15:0] lfsr = 16'hACE1;
    int busoff_entries = 0;

    always #2 clk = ~clk;  // 250 MHz

    can_fault_conf u0 (
        .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .rx_err(rx_err),
        .rx_err_hi(rx_err_hi), .tx_ok(tx_ok), .rx_ok(rx_ok), .idle11(idle11),
        .tec(tec), .rec(rec), .tx_warn(tx_warn), .rx_warn(rx_warn),
        .tx_passive(tx_passive), .rx_passive(rx_passive), .bus_off(bus_off),
        .err_state(err_state), .flag_recessive(flag_recessive));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the bench model.
    task automatic check_all();
        int bo, ps;
        bo = (mtec >= 256);
        ps = (!bo && (mtec >= 128 || mrec >= 128));
        chk("R2 tec", int'(tec), mtec);
        chk("R3 rec", int'(rec), mrec);
        chk("R5 tx_warn", int'(tx_warn), int'(mtec >= 96));
        chk("R5 rx_warn", int'(rx_warn), int'(mrec >= 96));
        chk("R6 tx_passive", int'(tx_passive), int'(mtec >= 128));
        chk("R6 rx_passive", int'(rx_passive), int'(mrec >= 128));
        chk("R6 flag_recessive", int'(flag_recessive), ps);
        chk("R7 bus_off", int'(bus_off), bo);
        chk("R7 err_state", int'(err_state), bo ? 2 : (ps ? 1 : 0));
    endtask

    // Apply one cycle of strobes, update the model, compare after the edge.
    task automatic step(input logic te, input logic re, input logic rh,
                        input logic to, input logic ro, input logic id);
        {tx_err, rx_err, rx_err_hi, tx_ok, rx_ok, idle11} = {te, re, rh, to, ro, id};
        @(posedge clk);
        if (mtec >= 256) begin
            if (id) begin
                mrc++;
                if (mrc == 128) begin mtec = 0; mrec = 0; mrc = 0; end
            end
        end else begin
            mrc = 0;
            if (te) mtec += 8;
            else if (to && mtec > 0) mtec -= 1;
            if (rh) mrec = (mrec + 8 > 255) ? 255 : mrec + 8;
            else if (re) mrec = (mrec + 1 > 255) ? 255 : mrec + 1;
            else if (ro) mrec = (mrec > 127) ? 127 : ((mrec > 0) ? mrec - 1 : 0);
            if (mtec >= 256) busoff_entries++;
        end
        @(negedge clk);
        {tx_err, rx_err, rx_err_hi, tx_ok, rx_ok, idle11} = '0;
        check_all();
    endtask

    initial begin
        int tmo = 0;
        while (tmo < 190000) begin @(posedge clk); tmo++; end
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all();
        chk("R1 reset tec", int'(tec), 0);
        chk("R1 reset state", int'(err_state), 0);
        rst_n = 1'b1;

        // R8: idle11 outside bus off does nothing
        repeat (5) step(0, 0, 0, 0, 0, 1);
        // R2: tx_ok floor at zero, tx_err wins over tx_ok
        step(0, 0, 0, 1, 0, 0);
        step(1, 0, 0, 1, 0, 0);
        chk("R2 err beats ok", int'(tec), 8);
        // R3/R4: drive rec to 255 with severe errors, then clip to 127 on success
        repeat (34) step(0, 0, 1, 0, 0, 0);
        chk("R3 saturate", int'(rec), 255);
        step(0, 1, 0, 0, 1, 0);
        chk("R4 err beats ok", int'(rec), 255);
        step(0, 0, 0, 0, 1, 0);
        chk("R4 clip to 127", int'(rec), 127);
        step(0, 0, 0, 0, 1, 0);
        chk("R4 decrement", int'(rec), 126);
        // R5 boundary: sweep rec down through 96 and 0
        repeat (130) step(0, 0, 0, 0, 1, 0);
        chk("R4 zero stays", int'(rec), 0);
        // R7: to bus off; strobes ignored
        repeat (31) step(1, 0, 0, 0, 0, 0);
        chk("R7 bus off", int'(bus_off), 1);
        step(1, 1, 1, 1, 1, 0);
        // R8: exactly 128 detections, with gaps
        for (int i = 0; i < 127; i++) step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0);
        chk("R8 not yet", int'(bus_off), 1);
        step(0, 0, 0, 0, 0, 1);
        chk("R8 recovered", int'(err_state), 0);

        // Model-compared pseudo-random sweep in phases with varying bias
        for (int ph = 0; ph < 16; ph++) begin
            for (int c = 0; c < 2500; c++) begin
                logic [15:0] r;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                r = lfsr;
                if (ph[0])
                    step(r[0] & r[1], r[2] & r[3], r[4] & r[5] & r[6],
                         r[7], r[8], r[9]);
                else
                    step(r[0] & r[1] & r[2] & r[3], r[4] & r[5] & r[11], r[6] & r[7] & r[8] & r[12],
                         r[9] | r[13], r[10] | r[14], r[15]);
            end
        end
        chk("R7 bus-off entries seen", int'(busoff_entries > 1), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule